// File: doc/BRIEF.md
# March C+ Element Sequencer

This block is the top-level step controller of a hardwired memory self-test. It does not touch the memory itself. It decides which march element runs next, and in which address direction, and it hands each element to a separate executor. The executor walks the addresses, generates the data and compares the reads. The sequence is fixed to the six elements of March C+, which adds up to 14 memory operations per word.

After reset the sequencer sits idle until `start_test` is raised. It then presents the first element on `march_ele` and `updown_order` and raises `start_march`. It holds that request until the executor answers with `end_march`. It then drops `start_march` for one cycle and presents the next element. After the sixth element completes it raises `end_test`. It keeps `end_test` high until `start_test` is withdrawn, and then returns to idle.

Top module: `march_seq_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous), and after it is released, `start_march` = 0, `end_test` = 0, `march_ele` = 2'b00 and `updown_order` = 1.
- R2: While idle and `start_test` = 0, `start_march` stays 0. An `end_march` pulse in idle has no effect on any output.
- R3: At the first clock edge that samples `start_test` = 1 in idle, `start_march` goes to 1 with the first element (code 2'b00, ascending). The same holds when a new test starts after a completed one.
- R4: The elements are issued in this order as {code, direction}: {00,up}, {01,up}, {10,up}, {01,down}, {10,down}, {11,up}. The codes mean 00 = write 0, 01 = read 0/write 1/read 1, 10 = read 1/write 0/read 0, 11 = read 0.
- R5: `updown_order` = 1 requests ascending addresses and 0 requests descending addresses.
- R6: While `start_march` = 1 and `end_march` = 0, `start_march`, `march_ele` and `updown_order` hold their values.
- R7: The clock edge that samples `end_march` = 1 while `start_march` = 1 drives `start_march` to 0 for exactly one cycle. The next element is then presented with `start_march` = 1.
- R8: `end_test` is 0 throughout the run. It becomes 1 at the edge that samples `end_march` for the sixth element, with `start_march` = 0. `start_march` and `end_test` are never both 1.
- R9: `end_test` stays 1 while `start_test` = 1. The edge that samples `start_test` = 0 returns the block to idle, with `end_test` = 0.
- R10: The operation counts of the issued element codes (1, 3, 3, 1 for codes 00, 01, 10, 11) sum to 14 per word over one run.
- R11: An `end_march` pulse during the one-cycle gap between elements is ignored. The following element is still issued and held until its own `end_march`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_test | input | 1 | Request to run the test; keep high until `end_test` is seen |
| end_march | input | 1 | Executor reports that the current element has finished |
| end_test | output | 1 | All six elements have completed |
| start_march | output | 1 | Element request to the executor |
| march_ele | output | 2 | Code of the current element |
| updown_order | output | 1 | Address direction: 1 ascending, 0 descending |

## Verification
Every output comes straight from a register, so each response appears one clock edge after the input that causes it. A `start_test` or `end_march` sampled at an edge shows on the outputs just after that same edge. The second element appears after one further edge, once the one-cycle gap has passed. The only exception is the asynchronous reset, which clears the outputs without waiting for a clock. The bench drives inputs two time units after a rising edge and reads outputs at that same point. Each check therefore sees the state produced by exactly one edge, and the sequence is checked element by element, including the gap cycle and the completion cycle.

// File: rtl/march_seq_pkg.sv
package march_seq_pkg;

    // Controller phase
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    // One march element as seen by the executor
    typedef struct packed {
        logic [1:0] code;
        logic       up;
    } elem_t;

    localparam int unsigned NUM_ELEM = 6;

endpackage

// File: rtl/march_elem_rom.sv
module march_elem_rom
    import march_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 3
) (
    input  logic [IDX_W-1:0] idx,
    output elem_t            elem
);

    // March C+ element list, computed per index
    always_comb begin
        unique case (idx)
            IDX_W'(0): elem = '{code: 2'b00, up: 1'b1};
            IDX_W'(1): elem = '{code: 2'b01, up: 1'b1};
            IDX_W'(2): elem = '{code: 2'b10, up: 1'b1};
            IDX_W'(3): elem = '{code: 2'b01, up: 1'b0};
            IDX_W'(4): elem = '{code: 2'b10, up: 1'b0};
            default:   elem = '{code: 2'b11, up: 1'b1};
        endcase
    end

endmodule

// File: rtl/march_step_ctr.sv
module march_step_ctr #(
    parameter int unsigned NUM_STEPS = 6,
    localparam int unsigned IDX_W    = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr) begin
            idx_d = '0;
        end else if (adv && (idx_q != LAST_IDX)) begin
            idx_d = idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else begin
            idx_q <= idx_d;
        end
    end

    assign idx  = idx_q;
    assign last = (idx_q == LAST_IDX);

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX) else $error("step index out of range"); // R4

endmodule

// File: rtl/march_seq_ctrl.sv
module march_seq_ctrl
    import march_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_test,
    input  logic       end_march,
    output logic       end_test,
    output logic       start_march,
    output logic [1:0] march_ele,
    output logic       updown_order
);

    localparam int unsigned IDX_W = $clog2(NUM_ELEM);

    typedef struct packed {
        seq_state_e state;
    } ctrl_t;

    ctrl_t            ctrl_d, ctrl_q;
    logic             step_clr, step_adv, step_last;
    logic [IDX_W-1:0] step_idx;
    elem_t            cur_elem;

    march_step_ctr #(
        .NUM_STEPS (NUM_ELEM)
    ) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (step_clr),
        .adv   (step_adv),
        .idx   (step_idx),
        .last  (step_last)
    );

    march_elem_rom #(
        .IDX_W (IDX_W)
    ) u_rom (
        .idx  (step_idx),
        .elem (cur_elem)
    );

    always_comb begin
        ctrl_d   = ctrl_q;
        step_clr = 1'b0;
        step_adv = 1'b0;
        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (start_test) begin
                    ctrl_d.state = ST_ISSUE;
                    step_clr     = 1'b1;
                end
            end
            ST_ISSUE: begin
                if (end_march) begin
                    if (step_last) begin
                        ctrl_d.state = ST_DONE;
                    end else begin
                        ctrl_d.state = ST_GAP;
                        step_adv     = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                ctrl_d.state = ST_ISSUE;
            end
            default: begin
                if (!start_test) begin
                    ctrl_d.state = ST_IDLE;
                    step_clr     = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign start_march  = (ctrl_q.state == ST_ISSUE);
    assign end_test     = (ctrl_q.state == ST_DONE);
    assign march_ele    = cur_elem.code;
    assign updown_order = cur_elem.up;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == ST_IDLE) && !start_test |=> !start_march && !end_test)
        else $error("left idle without start"); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        start_march && !end_march |=>
            start_march && $stable(march_ele) && $stable(updown_order))
        else $error("element request not held"); // R6

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        start_march && end_march |=> !start_march)
        else $error("request not dropped after completion"); // R7

    AST_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        start_march && end_march && !(march_ele == 2'b11) |=> ##1 start_march)
        else $error("gap longer than one cycle"); // R7

    AST_ORDER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        start_march && end_march && (march_ele == 2'b10) && updown_order |=>
            ##1 (march_ele == 2'b01) && !updown_order)
        else $error("direction change out of order"); // R4

    AST_EXCL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_march && end_test))
        else $error("request and completion together"); // R8

    AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        end_test && start_test |=> end_test)
        else $error("completion flag dropped early"); // R9

endmodule

// File: tb/sim_march_seq_ctrl.sv
module sim_march_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_test;
    logic       end_march;
    logic       end_test;
    logic       start_march;
    logic [1:0] march_ele;
    logic       updown_order;

    int n_chk  = 0;
    int n_fail = 0;
    int ops    = 0;

    always #5 clk = ~clk;

    march_seq_ctrl u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_test   (start_test),
        .end_march    (end_march),
        .end_test     (end_test),
        .start_march  (start_march),
        .march_ele    (march_ele),
        .updown_order (updown_order)
    );

    // {code[1:0], up, wait cycles[3:0]} per element
    localparam logic [6:0] VEC [6] = '{
        {2'b00, 1'b1, 4'd0},
        {2'b01, 1'b1, 4'd3},
        {2'b10, 1'b1, 4'd1},
        {2'b01, 1'b0, 4'd5},
        {2'b10, 1'b0, 4'd2},
        {2'b11, 1'b1, 4'd4}
    };

    function automatic int op_cost(logic [1:0] c);
        case (c)
            2'b00:   return 1;
            2'b11:   return 1;
            default: return 3;
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_test = 1'b0; end_march = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 start_march", start_march, 0);
        chk("R1 end_test", end_test, 0);
        chk("R1 march_ele", march_ele, 0);
        chk("R1 updown_order", updown_order, 1);

        // R2 end_march ignored in idle
        end_march = 1'b1;
        step();
        end_march = 1'b0;
        chk("R2 start_march idle", start_march, 0);
        chk("R2 end_test idle", end_test, 0);
        step();
        chk("R2 still idle", start_march, 0);

        start_test = 1'b1;
        step();
        chk("R3 start_march raised", start_march, 1);

        for (int i = 0; i < 6; i++) begin
            logic [1:0] ec;
            logic       eu;
            int         w;
            ec = VEC[i][6:5];
            eu = VEC[i][4];
            w  = int'(VEC[i][3:0]);
            chk($sformatf("R7 request elem %0d", i), start_march, 1);
            chk($sformatf("R4 code elem %0d", i), march_ele, ec);
            chk($sformatf("R5 dir elem %0d", i), updown_order, eu);
            for (int k = 0; k < w; k++) begin
                step();
                chk("R6 request held", start_march, 1);
                chk("R6 code held", march_ele, ec);
                chk("R6 dir held", updown_order, eu);
            end
            ops += op_cost(march_ele);
            end_march = 1'b1;
            step();
            end_march = 1'b0;
            if (i < 5) begin
                chk("R7 gap request low", start_march, 0);
                chk("R8 end_test low during run", end_test, 0);
                if (i == 2) begin
                    // R11 pulse during gap
                    end_march = 1'b1;
                    step();
                    end_march = 1'b0;
                    step();
                    chk("R11 request kept after gap pulse", start_march, 1);
                    chk("R11 next element kept", march_ele, VEC[3][6:5]);
                end else begin
                    step();
                end
            end else begin
                chk("R8 end_test high", end_test, 1);
                chk("R8 start_march low at end", start_march, 0);
            end
        end

        chk("R10 operations per word", ops, 14);

        for (int k = 0; k < 3; k++) begin
            step();
            chk("R9 end_test held", end_test, 1);
            chk("R8 no request after end", start_march, 0);
        end

        start_test = 1'b0;
        step();
        chk("R9 end_test cleared", end_test, 0);
        chk("R9 idle request low", start_march, 0);
        step();
        chk("R2 idle after finish", start_march, 0);

        start_test = 1'b1;
        step();
        chk("R3 restart request", start_march, 1);
        chk("R3 restart code", march_ele, 0);
        chk("R3 restart dir", updown_order, 1);

        // R1 asynchronous reset mid-run
        #1;
        rst_n = 1'b0;
        #1;
        chk("R1 async reset request", start_march, 0);
        chk("R1 async reset end_test", end_test, 0);
        start_test = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        chk("R1 idle after reset", start_march, 0);
        chk("R1 code after reset", march_ele, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule